// File: doc/BRIEF.md
# Serial Lane Bring-Up Sequencer

This block takes one serial transceiver lane from its reset state to carrying data. A start pulse captures the requested link type (the four-port quad serial gigabit interface, QSGMII, or the single-port serial gigabit interface, SGMII), whether the reference clock runs at 125 MHz, and whether the link runs at 2.5G. From those three choices it works out the PLL multiplier, the reference divide-by-2, the lane rate code and the 10-bit lane select. It then walks a fixed chain of enables, with a millisecond delay after each one, and samples four status inputs from the analog lane at set points.

If every status check reads the value 1, both data paths are enabled and a one-cycle done pulse is raised. The first check that reads anything else stops the chain. An error pulse is raised, and a code names the failed check. All control outputs keep the values they had at that point, so the failing step can be inspected. A single shared down-counter provides every delay. Its tick rate comes from a clock-frequency parameter, and a testbench can override it with a small value.

Top module: `lane_bringup_seq`

## Requirements
- R1: After reset, `lane_cfg_o` equals 32'h0804_0100, which has only the PHY reset (bit 27), TX reset (bit 18) and RX reset (bit 8) set. In the same state `ref_clk_en_o`, `pll_en_o`, `busy_o`, `done_o` and `err_o` are 0 and `err_code_o` is 0.
- R2: With `sgmii_i`=0, the 10-bit select (bit 10) is 0 and the TX rate (bits 17:16) and RX rate (bits 7:6) are 0. With `ref125_i`=1, `pll_mult_o` is 40 and `ref_div2_o` is 1. With `ref125_i`=0, they are 100 and 0. `fast_i` has no effect in this mode.
- R3: With `sgmii_i`=1, the 10-bit select is 1 and both rate fields are 1 when `fast_i`=1 and 2 when `fast_i`=0. With `ref125_i`=1, `pll_mult_o` is 50 (fast) or 40, and `ref_div2_o` is 1. With `ref125_i`=0, `pll_mult_o` is 125 (fast) or 100, and `ref_div2_o` is 0.
- R4: The first step sets the following, which stay constant for the rest of the run:
  - TX invert (bit 15) follows `tx_inv_i`, RX invert (bit 3) follows `rx_inv_i`, and loopback (bit 0) follows `loopbk_i`.
  - RX termination (bit 9) is 0.
  - TX reset and RX reset are 0.
- R5: The outputs change in this order, with at least N clock cycles between neighbours, where N is `TICKS_PER_MS` times the step's milliseconds:
  - `ref_clk_en_o` rises;
  - after 1 ms, PHY reset (bit 27) falls;
  - after 1 ms, `pll_en_o` rises;
  - after 7 ms, TX common-mode enable (bit 11) rises;
  - after 1 ms, RX PLL enable (bit 5) and TX enable (bit 14) rise in the same cycle;
  - after 1 ms, the data enables rise.
- R6: At the end of the 7 ms wait, a `pll_stat_i` value other than 1 ends the run with `err_code_o`=1, and TX common-mode enable is never raised.
- R7: At the end of the wait after TX common-mode enable, a `txcm_stat_i` value other than 1 ends the run with `err_code_o`=2, and neither RX PLL enable nor TX enable is raised.
- R8: At the end of the last wait, `rxpll_stat_i` is checked before `txst_stat_i`. A value other than 1 gives code 3 or code 4 respectively. When both fail, the code is 3.
- R9: When every check passes, TX data enable (bit 12) and RX data enable (bit 2) rise in the same cycle as a one-cycle `done_o` pulse, and `err_code_o` is 0.
- R10: On a failed check, `err_o` pulses for one cycle with a nonzero code. The data enables stay 0, every other output keeps its last value, and the code holds until the next start.
- R11: `busy_o` rises on the edge that accepts `start_i` and falls on the edge that raises `done_o` or `err_o`. A `start_i` while busy has no effect, neither on the running settings nor as a second run.
- R12: A start accepted while idle first sets PHY, TX and RX reset to 1 and clears every enable before the sequence replays. This applies after done as well as after an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start request, sampled while idle |
| sgmii_i | input | 1 | 1 selects SGMII, 0 selects QSGMII |
| ref125_i | input | 1 | Reference clock is 125 MHz |
| fast_i | input | 1 | 2.5G speed (SGMII only) |
| tx_inv_i | input | 1 | Requested TX polarity inversion |
| rx_inv_i | input | 1 | Requested RX polarity inversion |
| loopbk_i | input | 1 | Requested TX-to-RX lane loopback |
| pll_stat_i | input | STAT_W | PLL state status, 1 means ready |
| txcm_stat_i | input | STAT_W | TX common-mode state status |
| rxpll_stat_i | input | STAT_W | RX PLL state status |
| txst_stat_i | input | STAT_W | TX state status |
| lane_cfg_o | output | CFG_W | Lane configuration word |
| pll_mult_o | output | 8 | PLL multiplier |
| ref_div2_o | output | 1 | Reference divide-by-2 |
| ref_clk_en_o | output | 1 | Reference clock enable |
| pll_en_o | output | 1 | PLL enable |
| busy_o | output | 1 | Sequence running |
| done_o | output | 1 | One-cycle success pulse |
| err_o | output | 1 | One-cycle failure pulse |
| err_code_o | output | 3 | 0 none, 1 PLL, 2 TX common mode, 3 RX PLL, 4 TX state |

## Verification
The bound checker watches several properties on every cycle:
- the PLL enable only after the PHY reset release;
- the data enables only on top of all earlier enables;
- a done pulse always carrying both data enables;
- an error pulse always with a nonzero code and data disabled;
- busy low at either end pulse;
- a legal multiplier whenever the PLL is on;
- the 7 ms PLL interval, counted in cycles.

Only the bench scenarios can show the following:
- the mode-to-settings lookup;
- the minimum length of every other interval;
- which code each status pattern gives, including the RX-PLL-over-TX precedence and status values of 2 or 3;
- that outputs freeze at the failing step;
- that a start request arriving in mid-run is ignored;
- that a restart re-asserts the resets.

// File: rtl/lane_seq_pkg.sv
package lane_seq_pkg;

  localparam int MULT_W = 8;

  // Multiplier choices, per reference clock and speed
  localparam logic [MULT_W-1:0] MUL_R125_BASE = 8'd40;
  localparam logic [MULT_W-1:0] MUL_R125_FAST = 8'd50;
  localparam logic [MULT_W-1:0] MUL_RALT_BASE = 8'd100;
  localparam logic [MULT_W-1:0] MUL_RALT_FAST = 8'd125;

  localparam logic [1:0] RATE_FULL = 2'd0;
  localparam logic [1:0] RATE_HALF = 2'd1;
  localparam logic [1:0] RATE_QRTR = 2'd2;

  typedef enum logic [2:0] {
    FAIL_NONE  = 3'd0,
    FAIL_PLL   = 3'd1,
    FAIL_TXCM  = 3'd2,
    FAIL_RXPLL = 3'd3,
    FAIL_TXST  = 3'd4
  } fail_code_e;

  typedef struct packed {
    logic              sel10;
    logic              div2;
    logic [1:0]        rate;
    logic [MULT_W-1:0] mult;
  } rate_set_t;

  typedef struct packed {
    logic       phy_rst;
    logic       tx_rst;
    logic [1:0] tx_rate;
    logic       tx_inv;
    logic       tx_en;
    logic       tx_data_en;
    logic       txcm_en;
    logic       sel10;
    logic       rx_term;
    logic       rx_rst;
    logic [1:0] rx_rate;
    logic       rxpll_en;
    logic       rx_inv;
    logic       rx_data_en;
    logic       loopbk;
  } lane_ctl_t;

  localparam lane_ctl_t CTL_RST = '{phy_rst: 1'b1, tx_rst: 1'b1, rx_rst: 1'b1, default: '0};

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOAD,
    S_REFON,
    S_W_REF,
    S_W_PHY,
    S_W_PLL,
    S_W_CM,
    S_W_LANE
  } seq_state_e;

endpackage

// File: rtl/lane_rate_lut.sv
module lane_rate_lut
  import lane_seq_pkg::*;
(
  input  logic      sgmii_i,
  input  logic      ref125_i,
  input  logic      fast_i,
  output rate_set_t set_o
);

  always_comb begin
    set_o      = '0;
    set_o.div2 = ref125_i;
    if (!sgmii_i) begin
      set_o.sel10 = 1'b0;
      set_o.rate  = RATE_FULL;
      set_o.mult  = ref125_i ? MUL_R125_BASE : MUL_RALT_BASE;
    end else begin
      set_o.sel10 = 1'b1;
      set_o.rate  = fast_i ? RATE_HALF : RATE_QRTR;
      if (ref125_i) set_o.mult = fast_i ? MUL_R125_FAST : MUL_R125_BASE;
      else          set_o.mult = fast_i ? MUL_RALT_FAST : MUL_RALT_BASE;
    end
  end

endmodule

// File: rtl/lane_cfg_pack.sv
module lane_cfg_pack
  import lane_seq_pkg::*;
#(
  parameter int CFG_W = 32
) (
  input  lane_ctl_t        ctl_i,
  output logic [CFG_W-1:0] word_o
);

  // Field positions decoded by the lane
  localparam int B_PHY_RST  = 27;
  localparam int B_TX_RST   = 18;
  localparam int B_TX_RATE  = 16;
  localparam int B_TX_INV   = 15;
  localparam int B_TX_EN    = 14;
  localparam int B_TX_DATA  = 12;
  localparam int B_TXCM     = 11;
  localparam int B_SEL10    = 10;
  localparam int B_RX_TERM  = 9;
  localparam int B_RX_RST   = 8;
  localparam int B_RX_RATE  = 6;
  localparam int B_RXPLL    = 5;
  localparam int B_RX_INV   = 3;
  localparam int B_RX_DATA  = 2;
  localparam int B_LOOPBK   = 0;

  always_comb begin
    word_o                        = '0;
    word_o[B_PHY_RST]             = ctl_i.phy_rst;
    word_o[B_TX_RST]              = ctl_i.tx_rst;
    word_o[B_TX_RATE+1:B_TX_RATE] = ctl_i.tx_rate;
    word_o[B_TX_INV]              = ctl_i.tx_inv;
    word_o[B_TX_EN]               = ctl_i.tx_en;
    word_o[B_TX_DATA]             = ctl_i.tx_data_en;
    word_o[B_TXCM]                = ctl_i.txcm_en;
    word_o[B_SEL10]               = ctl_i.sel10;
    word_o[B_RX_TERM]             = ctl_i.rx_term;
    word_o[B_RX_RST]              = ctl_i.rx_rst;
    word_o[B_RX_RATE+1:B_RX_RATE] = ctl_i.rx_rate;
    word_o[B_RXPLL]               = ctl_i.rxpll_en;
    word_o[B_RX_INV]              = ctl_i.rx_inv;
    word_o[B_RX_DATA]             = ctl_i.rx_data_en;
    word_o[B_LOOPBK]              = ctl_i.loopbk;
  end

endmodule

// File: rtl/lane_ms_timer.sv
module lane_ms_timer #(
  parameter int TICKS_PER_MS = 125000,
  parameter int MAX_MS       = 7,
  localparam int MS_W        = $clog2(MAX_MS + 1),
  localparam int CNT_W       = $clog2(MAX_MS * TICKS_PER_MS + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_i,
  input  logic [MS_W-1:0] ms_i,
  output logic            zero_o
);

  localparam logic [CNT_W-1:0] TICKS_C = CNT_W'(TICKS_PER_MS);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= CNT_W'(ms_i) * TICKS_C;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/lane_bringup_seq.sv
module lane_bringup_seq
  import lane_seq_pkg::*;
#(
  parameter int CLK_HZ       = 125_000_000,
  parameter int TICKS_PER_MS = CLK_HZ / 1000,
  parameter int MS_STEP      = 1,
  parameter int MS_PLL       = 7,
  parameter int STAT_W       = 2,
  parameter int CFG_W        = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              sgmii_i,
  input  logic              ref125_i,
  input  logic              fast_i,
  input  logic              tx_inv_i,
  input  logic              rx_inv_i,
  input  logic              loopbk_i,
  input  logic [STAT_W-1:0] pll_stat_i,
  input  logic [STAT_W-1:0] txcm_stat_i,
  input  logic [STAT_W-1:0] rxpll_stat_i,
  input  logic [STAT_W-1:0] txst_stat_i,
  output logic [CFG_W-1:0]  lane_cfg_o,
  output logic [7:0]        pll_mult_o,
  output logic              ref_div2_o,
  output logic              ref_clk_en_o,
  output logic              pll_en_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [2:0]        err_code_o
);

  localparam int MAX_MS = (MS_PLL > MS_STEP) ? MS_PLL : MS_STEP;
  localparam int MS_W   = $clog2(MAX_MS + 1);
  localparam logic [STAT_W-1:0] STAT_OK = STAT_W'(1);

  seq_state_e        state_q;
  lane_ctl_t         ctl_q;
  rate_set_t         rset;
  fail_code_e        code_q;
  logic [MULT_W-1:0] mult_q;
  logic              div2_q, refen_q, pllen_q, busy_q, done_q, err_q;
  logic              lat_sgmii, lat_ref, lat_fast, lat_txi, lat_rxi, lat_lb;
  logic              tmr_load, tmr_zero;
  logic [MS_W-1:0]   tmr_ms;

  lane_rate_lut u_lut (
    .sgmii_i  (lat_sgmii),
    .ref125_i (lat_ref),
    .fast_i   (lat_fast),
    .set_o    (rset)
  );

  lane_ms_timer #(
    .TICKS_PER_MS (TICKS_PER_MS),
    .MAX_MS       (MAX_MS)
  ) u_tmr (
    .clk    (clk),
    .rst    (rst),
    .load_i (tmr_load),
    .ms_i   (tmr_ms),
    .zero_o (tmr_zero)
  );

  lane_cfg_pack #(.CFG_W(CFG_W)) u_pack (
    .ctl_i  (ctl_q),
    .word_o (lane_cfg_o)
  );

  // Timer reload: entering each timed step
  always_comb begin
    tmr_load = 1'b0;
    tmr_ms   = MS_W'(MS_STEP);
    unique case (state_q)
      S_REFON:  tmr_load = 1'b1;
      S_W_REF:  tmr_load = tmr_zero;
      S_W_PHY: begin
        tmr_load = tmr_zero;
        tmr_ms   = MS_W'(MS_PLL);
      end
      S_W_PLL:  tmr_load = tmr_zero;
      S_W_CM:   tmr_load = tmr_zero;
      default:  tmr_load = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= S_IDLE;
      ctl_q     <= CTL_RST;
      mult_q    <= '0;
      div2_q    <= 1'b0;
      refen_q   <= 1'b0;
      pllen_q   <= 1'b0;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      code_q    <= FAIL_NONE;
      lat_sgmii <= 1'b0;
      lat_ref   <= 1'b0;
      lat_fast  <= 1'b0;
      lat_txi   <= 1'b0;
      lat_rxi   <= 1'b0;
      lat_lb    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (start_i) begin
            lat_sgmii <= sgmii_i;
            lat_ref   <= ref125_i;
            lat_fast  <= fast_i;
            lat_txi   <= tx_inv_i;
            lat_rxi   <= rx_inv_i;
            lat_lb    <= loopbk_i;
            ctl_q     <= CTL_RST;
            refen_q   <= 1'b0;
            pllen_q   <= 1'b0;
            busy_q    <= 1'b1;
            code_q    <= FAIL_NONE;
            state_q   <= S_LOAD;
          end
        end
        S_LOAD: begin
          ctl_q.sel10   <= rset.sel10;
          ctl_q.tx_rate <= rset.rate;
          ctl_q.rx_rate <= rset.rate;
          ctl_q.tx_inv  <= lat_txi;
          ctl_q.rx_inv  <= lat_rxi;
          ctl_q.loopbk  <= lat_lb;
          ctl_q.tx_rst  <= 1'b0;
          ctl_q.rx_rst  <= 1'b0;
          ctl_q.rx_term <= 1'b0;
          mult_q        <= rset.mult;
          div2_q        <= rset.div2;
          state_q       <= S_REFON;
        end
        S_REFON: begin
          refen_q <= 1'b1;
          state_q <= S_W_REF;
        end
        S_W_REF: begin
          if (tmr_zero) begin
            ctl_q.phy_rst <= 1'b0;
            state_q       <= S_W_PHY;
          end
        end
        S_W_PHY: begin
          if (tmr_zero) begin
            pllen_q <= 1'b1;
            state_q <= S_W_PLL;
          end
        end
        S_W_PLL: begin
          if (tmr_zero) begin
            if (pll_stat_i != STAT_OK) begin
              code_q  <= FAIL_PLL;
              err_q   <= 1'b1;
              busy_q  <= 1'b0;
              state_q <= S_IDLE;
            end else begin
              ctl_q.txcm_en <= 1'b1;
              state_q       <= S_W_CM;
            end
          end
        end
        S_W_CM: begin
          if (tmr_zero) begin
            if (txcm_stat_i != STAT_OK) begin
              code_q  <= FAIL_TXCM;
              err_q   <= 1'b1;
              busy_q  <= 1'b0;
              state_q <= S_IDLE;
            end else begin
              ctl_q.rxpll_en <= 1'b1;
              ctl_q.tx_en    <= 1'b1;
              state_q        <= S_W_LANE;
            end
          end
        end
        S_W_LANE: begin
          if (tmr_zero) begin
            busy_q  <= 1'b0;
            state_q <= S_IDLE;
            if (rxpll_stat_i != STAT_OK) begin
              code_q <= FAIL_RXPLL;
              err_q  <= 1'b1;
            end else if (txst_stat_i != STAT_OK) begin
              code_q <= FAIL_TXST;
              err_q  <= 1'b1;
            end else begin
              ctl_q.tx_data_en <= 1'b1;
              ctl_q.rx_data_en <= 1'b1;
              done_q           <= 1'b1;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign pll_mult_o   = mult_q;
  assign ref_div2_o   = div2_q;
  assign ref_clk_en_o = refen_q;
  assign pll_en_o     = pllen_q;
  assign busy_o       = busy_q;
  assign done_o       = done_q;
  assign err_o        = err_q;
  assign err_code_o   = code_q;

endmodule

// File: rtl/lane_bringup_chk.sv
module lane_bringup_chk #(
  parameter int TICKS_PER_MS = 1,
  parameter int MS_PLL       = 7,
  parameter int CFG_W        = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             done_o,
  input logic             err_o,
  input logic [2:0]       err_code_o,
  input logic             busy_o,
  input logic [CFG_W-1:0] lane_cfg_o,
  input logic             pll_en_o,
  input logic             ref_clk_en_o,
  input logic [7:0]       pll_mult_o
);

  localparam int PLL_TICKS = MS_PLL * TICKS_PER_MS;
  localparam int CW        = $clog2(PLL_TICKS + 2);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic [CW-1:0] pll_cnt;
  logic          pll_q;

  // Cycles since the PLL enable rose, saturating
  always_ff @(posedge clk) begin
    if (rst) begin
      pll_cnt <= '0;
      pll_q   <= 1'b0;
    end else begin
      pll_q <= pll_en_o;
      if (pll_en_o && !pll_q)      pll_cnt <= '0;
      else if (pll_cnt != CNT_MAX) pll_cnt <= pll_cnt + 1'b1;
    end
  end

  p_data_with_done_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (lane_cfg_o[12] && lane_cfg_o[2]));

  p_data_after_all_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(lane_cfg_o[2]) |-> (lane_cfg_o[14] && lane_cfg_o[5] && lane_cfg_o[11]
                              && pll_en_o && ref_clk_en_o && !lane_cfg_o[27]));

  p_pll_after_phy_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(pll_en_o) |-> (ref_clk_en_o && !lane_cfg_o[27]));

  p_pll_wait_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(lane_cfg_o[11]) |-> (pll_cnt >= CW'(PLL_TICKS)));

  p_err_state_r10: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (err_code_o != 3'd0 && !lane_cfg_o[12] && !lane_cfg_o[2]));

  p_busy_end_r11: assert property (@(posedge clk) disable iff (rst)
    (done_o || err_o) |-> !busy_o);

  p_mult_legal_r3: assert property (@(posedge clk) disable iff (rst)
    pll_en_o |-> (pll_mult_o == 8'd40 || pll_mult_o == 8'd50 ||
                  pll_mult_o == 8'd100 || pll_mult_o == 8'd125));

endmodule

bind lane_bringup_seq lane_bringup_chk #(
  .TICKS_PER_MS (TICKS_PER_MS),
  .MS_PLL       (MS_PLL),
  .CFG_W        (CFG_W)
) chk_i (
  .clk          (clk),
  .rst          (rst),
  .done_o       (done_o),
  .err_o        (err_o),
  .err_code_o   (err_code_o),
  .busy_o       (busy_o),
  .lane_cfg_o   (lane_cfg_o),
  .pll_en_o     (pll_en_o),
  .ref_clk_en_o (ref_clk_en_o),
  .pll_mult_o   (pll_mult_o)
);

// File: tb/lane_bringup_seq_tb_top.sv
module lane_bringup_seq_tb_top;

  localparam int TPM = 20;

  logic        clk = 1'b0;
  logic        rst;
  logic        start_i, sgmii_i, ref125_i, fast_i, tx_inv_i, rx_inv_i, loopbk_i;
  logic [1:0]  pll_stat_i, txcm_stat_i, rxpll_stat_i, txst_stat_i;
  logic [31:0] lane_cfg_o;
  logic [7:0]  pll_mult_o;
  logic        ref_div2_o, ref_clk_en_o, pll_en_o, busy_o, done_o, err_o;
  logic [2:0]  err_code_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  lane_bringup_seq #(.TICKS_PER_MS(TPM)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .sgmii_i(sgmii_i), .ref125_i(ref125_i),
    .fast_i(fast_i), .tx_inv_i(tx_inv_i), .rx_inv_i(rx_inv_i), .loopbk_i(loopbk_i),
    .pll_stat_i(pll_stat_i), .txcm_stat_i(txcm_stat_i), .rxpll_stat_i(rxpll_stat_i),
    .txst_stat_i(txst_stat_i), .lane_cfg_o(lane_cfg_o), .pll_mult_o(pll_mult_o),
    .ref_div2_o(ref_div2_o), .ref_clk_en_o(ref_clk_en_o), .pll_en_o(pll_en_o),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .err_code_o(err_code_o)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_mult(bit md, bit rf, bit fs);
    if (!md) return rf ? 8'd40 : 8'd100;
    if (rf)  return fs ? 8'd50 : 8'd40;
    return fs ? 8'd125 : 8'd100;
  endfunction

  function automatic logic [1:0] exp_rate(bit md, bit fs);
    if (!md) return 2'd0;
    return fs ? 2'd1 : 2'd2;
  endfunction

  function automatic int exp_code(logic [1:0] sp, logic [1:0] sc, logic [1:0] sr, logic [1:0] st);
    if (sp != 2'd1) return 1;
    if (sc != 2'd1) return 2;
    if (sr != 2'd1) return 3;
    if (st != 2'd1) return 4;
    return 0;
  endfunction

  task automatic run_case(input bit md, input bit rf, input bit fs, input bit ti,
                          input bit ri, input bit lb, input logic [1:0] sp,
                          input logic [1:0] sc, input logic [1:0] sr,
                          input logic [1:0] st, input bit poke);
    int  ec = exp_code(sp, sc, sr, st);
    int  cyc = 0;
    int  t_ref = -1, t_phy = -1, t_pll = -1, t_cm = -1, t_lane = -1, t_td = -1, t_rd = -1;
    bit  busy_ok = 1, fin = 0, dn = 0, er = 0;
    string mt = md ? "R3" : "R2";
    @(negedge clk);
    sgmii_i = md; ref125_i = rf; fast_i = fs; tx_inv_i = ti; rx_inv_i = ri; loopbk_i = lb;
    pll_stat_i = sp; txcm_stat_i = sc; rxpll_stat_i = sr; txst_stat_i = st;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    // R12: restart re-asserts resets and clears enables
    chk(lane_cfg_o[27] && lane_cfg_o[18] && lane_cfg_o[8] && !lane_cfg_o[11] && !lane_cfg_o[14]
        && !lane_cfg_o[12] && !lane_cfg_o[2] && !pll_en_o && !ref_clk_en_o && busy_o,
        "R12", "state after start", lane_cfg_o, 32'h0804_0100);
    while (!fin && cyc < 3000) begin
      if (ref_clk_en_o && t_ref < 0)    t_ref  = cyc;
      if (!lane_cfg_o[27] && t_phy < 0) t_phy  = cyc;
      if (pll_en_o && t_pll < 0)        t_pll  = cyc;
      if (lane_cfg_o[11] && t_cm < 0)   t_cm   = cyc;
      if (lane_cfg_o[14] && lane_cfg_o[5] && t_lane < 0) t_lane = cyc;
      if (lane_cfg_o[12] && t_td < 0)   t_td   = cyc;
      if (lane_cfg_o[2] && t_rd < 0)    t_rd   = cyc;
      if (done_o || err_o) begin
        fin = 1; dn = done_o; er = err_o;
      end else if (!busy_o) begin
        busy_ok = 0;
      end
      if (!fin) begin
        if (poke && cyc == 40) begin
          start_i = 1'b1; sgmii_i = !md; ref125_i = !rf;
        end
        if (poke && cyc == 41) begin
          start_i = 1'b0; sgmii_i = md; ref125_i = rf;
        end
        @(negedge clk);
        cyc++;
      end
    end
    chk(busy_ok && !busy_o, "R11", "busy held through run", busy_o, 0);
    if (ec == 0) begin
      chk(dn && !er && err_code_o == 3'd0, "R9", "done pulse", {dn, er, err_code_o}, 5'b10000);
      chk(t_td == cyc && t_rd == cyc, "R9", "data enables with done", t_td, cyc);
      chk(pll_mult_o == exp_mult(md, rf, fs) && ref_div2_o == rf, mt, "mult/div2",
          {pll_mult_o, ref_div2_o}, {exp_mult(md, rf, fs), rf});
      chk(lane_cfg_o[10] == md && lane_cfg_o[17:16] == exp_rate(md, fs)
          && lane_cfg_o[7:6] == exp_rate(md, fs), mt, "sel10/rates",
          {lane_cfg_o[17:16], lane_cfg_o[10], lane_cfg_o[7:6]}, {exp_rate(md, fs), md, exp_rate(md, fs)});
      chk(lane_cfg_o[15] == ti && lane_cfg_o[3] == ri && lane_cfg_o[0] == lb && !lane_cfg_o[9]
          && !lane_cfg_o[18] && !lane_cfg_o[8], "R4", "lane fields",
          {lane_cfg_o[15], lane_cfg_o[3], lane_cfg_o[0], lane_cfg_o[9]}, {ti, ri, lb, 1'b0});
      chk(t_ref >= 0 && (t_phy - t_ref) >= TPM && (t_pll - t_phy) >= TPM && (t_cm - t_pll) >= 7*TPM
          && (t_lane - t_cm) >= TPM && (t_td - t_lane) >= TPM, "R5", "step order and waits",
          t_cm - t_pll, 7*TPM);
    end else begin
      string et = (ec == 1) ? "R6" : (ec == 2) ? "R7" : "R8";
      chk(er && !dn && int'(err_code_o) == ec, et, "error code", err_code_o, ec);
      chk(!lane_cfg_o[12] && !lane_cfg_o[2] && !lane_cfg_o[27] && pll_en_o && ref_clk_en_o,
          "R10", "frozen state after error", lane_cfg_o, 0);
      if (ec == 1)
        chk(!lane_cfg_o[11] && (t_pll - t_phy) >= TPM, "R6", "no CM enable", lane_cfg_o[11], 0);
      else if (ec == 2)
        chk(lane_cfg_o[11] && !lane_cfg_o[14] && !lane_cfg_o[5], "R7", "no lane enables",
            {lane_cfg_o[14], lane_cfg_o[5]}, 0);
      else
        chk(lane_cfg_o[14] && lane_cfg_o[5] && (t_lane - t_cm) >= TPM, "R8", "lane enables kept",
            {lane_cfg_o[14], lane_cfg_o[5]}, 3);
    end
    if (poke || ec != 0) begin
      bit stay = 1;
      for (int k = 0; k < 30; k++) begin
        @(negedge clk);
        if (busy_o || done_o || err_o) stay = 0;
      end
      chk(stay && lane_cfg_o[10] == md && pll_mult_o == exp_mult(md, rf, fs), "R11",
          "mid-run start ignored", {lane_cfg_o[10], pll_mult_o}, {md, exp_mult(md, rf, fs)});
      if (ec != 0)
        chk(int'(err_code_o) == ec, "R10", "code held in idle", err_code_o, ec);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst = 1'b1; start_i = 0; sgmii_i = 0; ref125_i = 0; fast_i = 0;
    tx_inv_i = 0; rx_inv_i = 0; loopbk_i = 0;
    pll_stat_i = 1; txcm_stat_i = 1; rxpll_stat_i = 1; txst_stat_i = 1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(lane_cfg_o == 32'h0804_0100, "R1", "reset cfg word", lane_cfg_o, 32'h0804_0100);
    chk(!busy_o && !done_o && !err_o && !pll_en_o && !ref_clk_en_o && err_code_o == 0,
        "R1", "reset flags", {busy_o, done_o, err_o, pll_en_o, ref_clk_en_o}, 0);

    // R2/R3: every mode, reference and speed combination
    for (int m = 0; m < 8; m++)
      run_case(m[2], m[1], m[0], m[0], m[1], m[2], 2'd1, 2'd1, 2'd1, 2'd1, m == 5);

    // Directed failures: R6, R7, R8
    run_case(1, 1, 0, 0, 0, 0, 2'd0, 2'd1, 2'd1, 2'd1, 0);
    run_case(0, 1, 0, 1, 0, 0, 2'd2, 2'd1, 2'd1, 2'd1, 0);
    run_case(1, 0, 1, 0, 1, 1, 2'd1, 2'd3, 2'd1, 2'd1, 1);
    run_case(1, 1, 1, 0, 0, 0, 2'd1, 2'd1, 2'd0, 2'd1, 0);
    run_case(0, 0, 0, 0, 0, 1, 2'd1, 2'd1, 2'd1, 2'd2, 0);
    run_case(1, 0, 0, 1, 1, 0, 2'd1, 2'd1, 2'd0, 2'd0, 0);

    // Random mix
    for (int n = 0; n < 20; n++) begin
      logic [1:0] s[4];
      int r = int'($urandom % 6);
      for (int k = 0; k < 4; k++) s[k] = 2'd1;
      if (r >= 4) s[$urandom % 4] = ($urandom % 2) ? 2'd0 : 2'd2;
      if (r == 5) s[$urandom % 4] = 2'd3;
      run_case(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
               1'($urandom), s[0], s[1], s[2], s[3], (n % 4) == 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule